// File: doc/BRIEF.md
# Avionics Word Serial Transmitter Channel

This block is one transmit channel for a point-to-point avionics data bus. Each bus word is 32 bits long. A host builds each word through a byte-wide register port. The channel holds finished words in a small FIFO. It computes the word's parity bit and serializes the word onto two digital drive lines that feed an external line driver. The outputs are high, low or null: a one is sent as high, a zero as low, and null is both lines released. The bit rate is chosen per channel between a slow rate of 12.5 kbit/s and a fast rate of 100 kbit/s. Bit timing comes from a divider of the system clock, and the clock frequency is a parameter, so 16 MHz and 20 MHz systems are both covered.

Every bit cell is return-to-zero. The first half of the cell drives the bit level and the second half is null. A quiet interval of at least four bit-times separates consecutive words. The lowest eight bits of a word are the label, and they go out first, most significant label bit first. The rest of the word follows in ascending bit order, and the parity bit is last. The field above the label carries the source/destination identifier, then the data, then the sign/status bits. A wrap-around mode sends the waveform to a second pair of outputs that feeds a local receiver, and it holds the external pair at null.

The serializer is a state machine with five states. ST_IDLE waits for a word. It moves to ST_LOAD when transmit is enabled and the FIFO holds a word. ST_LOAD pops the word, orders the bits, starts the half-bit timer and moves to ST_MARK. ST_MARK drives the bit level and moves to ST_NULL after one half-bit. ST_NULL releases the lines for one half-bit. It then returns to ST_MARK for the next bit, or goes to ST_GAP after bit 32. ST_GAP holds null for eight half-bits and then returns to ST_IDLE.

Top module: `avword_tx`

## Requirements
- R1: After reset, all four drive outputs are 0 (null), the control register reads 0x00 and the status register reads 0x01.
- R2: Register index 0 is the word register. Writes with byte index 0, 1 and 2 store word bits 8:1, 16:9 and 24:17; these bytes read back from index 0, and byte index 3 reads 0. A write with byte index 3 supplies bits 31:25 from its data bits 6:0 and enqueues the assembled word. The first byte written with byte index 0 appears in word bits 8:1, so the whole word is sent unchanged apart from bit 32.
- R3: The transmitted bit 32 makes the count of ones over all 32 bits odd. Data bit 7 of the byte-index-3 write is ignored.
- R4: Word bits go out in this order: 8, 7, 6, 5, 4, 3, 2, 1, then 9 through 32 ascending.
- R5: A one is a cell with the high line 1 and the low line 0. A zero is a cell with the low line 1 and the high line 0. The two lines of a pair are never 1 together.
- R6: Each bit cell drives its level for exactly H clock cycles and is then null for exactly H cycles. H is CLK_HZ/200000 when control bit 0 is 1 (fast) and CLK_HZ/25000 when it is 0 (slow).
- R7: Between the end of one word's last driven half-cell and the next word's first driven half-cell, the pair stays null for at least 9·H cycles: the last bit's null half plus at least four bit-times.
- R8: Status register (index 2) bit 0 is FIFO empty, bit 1 is FIFO full (FIFO_DEPTH words held) and bit 3 is busy (a word in progress).
- R9: A word enqueue while the FIFO is full is dropped and sets the overflow flag, status bit 2. The flag stays set until the host writes index 2 with data bit 2 at 1.
- R10: With control bit 1 at 1 (wrap-around), the external pair stays null and the wrap pair carries the waveform. With it at 0, the wrap pair stays null.
- R11: With control bit 2 (transmit enable) at 0, queued words stay in the FIFO. Once it is set, the words are sent in the order they were enqueued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index: 0 word, 1 control, 2 status, 3 unused |
| byte_idx | input | 2 | Byte lane of the word register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for the selected register |
| line_hi | output | 1 | External driver, high level |
| line_lo | output | 1 | External driver, low level |
| wrap_hi | output | 1 | Wrap-around path, high level |
| wrap_lo | output | 1 | Wrap-around path, low level |

## Verification
The bench decodes the transmitted waveform at the pins. It rebuilds each word from the cell levels and times every driven and null half-cell.

- Bit order: a host word with distinct label bits exposes a design that sends the label least significant bit first, because the decoded label comes back mirrored.
- Parity: an all-ones host word shows whether the host's bit 32 is passed through or wrongly counted, since correct parity for that word is 0.
- Overflow: a fifth word written into a full FIFO must never appear on the line, and the overflow flag must survive until the host clears it.
- Gap: two back-to-back words show whether the gap is too short, and the slow-rate word shows whether the divider picks the wrong reload.
- Wrap-around: in wrap mode any activity on the external pair is counted as a leak, and in normal mode any activity on the wrap pair is counted as a leak.

// File: rtl/avtx_pkg.sv
package avtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MARK,
        ST_NULL,
        ST_GAP
    } tx_state_t;

    localparam int WORD_BITS  = 32;
    localparam int GAP_HALVES = 8;          // four bit-times of null
    localparam int FAST_DIV   = 200_000;    // half-cells per second at 100 kbit/s
    localparam int SLOW_DIV   = 25_000;     // half-cells per second at 12.5 kbit/s

    localparam logic [1:0] IDX_WORD = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam logic [1:0] IDX_STAT = 2'd2;

endpackage

// File: rtl/avtx_fifo.sv
module avtx_fifo #(
    parameter int WIDTH = 31,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    level;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));

endmodule

// File: rtl/avtx_halfbit.sv
module avtx_halfbit
    import avtx_pkg::*;
#(
    parameter int CLK_HZ = 16_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int HALF_FAST = CLK_HZ / FAST_DIV;
    localparam int HALF_SLOW = CLK_HZ / SLOW_DIV;
    localparam int CW        = $clog2(HALF_SLOW + 1);
    localparam logic [CW-1:0] RL_FAST = CW'(HALF_FAST - 1);
    localparam logic [CW-1:0] RL_SLOW = CW'(HALF_SLOW - 1);

    logic [CW-1:0] cnt;
    logic          fast_q;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            fast_q <= 1'b0;
        end else if (restart) begin
            fast_q <= fast;
            cnt    <= fast ? RL_FAST : RL_SLOW;
        end else if (tick) begin
            cnt    <= fast_q ? RL_FAST : RL_SLOW;
        end else begin
            cnt    <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/avtx_serializer.sv
module avtx_serializer
    import avtx_pkg::*;
#(
    parameter int CLK_HZ = 16_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        fast,
    input  logic        fifo_empty,
    input  logic [30:0] fifo_dout,
    output logic        fifo_pop,
    output logic        drv_hi,
    output logic        drv_lo,
    output logic        busy,
    output logic        quiet
);
    localparam int BCW = $clog2(WORD_BITS);
    localparam int GCW = $clog2(GAP_HALVES);

    tx_state_t       state, nxt;
    logic [31:0]     shreg;
    logic [BCW-1:0]  bit_cnt;
    logic [GCW-1:0]  gap_cnt;
    logic            tick;
    logic            restart;

    function automatic logic [31:0] order_bits(input logic [30:0] d);
        logic [31:0] w;
        logic [31:0] o;
        w = {~^d, d};
        for (int i = 0; i < WORD_BITS; i++) begin
            if (i < 8) o[i] = w[7-i];
            else       o[i] = w[i];
        end
        return o;
    endfunction

    avtx_halfbit #(.CLK_HZ(CLK_HZ)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .fast    (fast),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (enable && !fifo_empty) nxt = ST_LOAD;
            ST_LOAD: nxt = ST_MARK;
            ST_MARK: if (tick) nxt = ST_NULL;
            ST_NULL: if (tick) nxt = (bit_cnt == BCW'(WORD_BITS - 1)) ? ST_GAP : ST_MARK;
            ST_GAP:  if (tick && gap_cnt == GCW'(GAP_HALVES - 1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // word datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    shreg   <= order_bits(fifo_dout);
                    bit_cnt <= '0;
                end
                ST_NULL: if (tick) begin
                    shreg   <= shreg >> 1;
                    bit_cnt <= bit_cnt + 1'b1;
                    gap_cnt <= '0;
                end
                ST_GAP: if (tick) gap_cnt <= gap_cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fifo_pop = 1'b0;
        restart  = 1'b0;
        drv_hi   = 1'b0;
        drv_lo   = 1'b0;
        quiet    = 1'b0;
        unique case (state)
            ST_IDLE: quiet = 1'b1;
            ST_LOAD: begin
                fifo_pop = 1'b1;
                restart  = 1'b1;
            end
            ST_MARK: begin
                drv_hi = shreg[0];
                drv_lo = !shreg[0];
            end
            ST_NULL: ;
            ST_GAP:  quiet = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/avword_tx.sv
module avword_tx
    import avtx_pkg::*;
#(
    parameter int CLK_HZ     = 16_000_000,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_idx,
    input  logic [1:0] byte_idx,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       line_hi,
    output logic       line_lo,
    output logic       wrap_hi,
    output logic       wrap_lo
);
    logic [7:0]  stage [3];
    logic [2:0]  ctl;
    logic        ovf_q;
    logic        push_req, fifo_push, ovf_clr;
    logic        fifo_pop, fifo_empty, fifo_full;
    logic [30:0] fifo_dout;
    logic        drv_hi, drv_lo, busy, tx_quiet;
    logic        ctl_fast, ctl_wrap, ctl_en;

    assign ctl_fast = ctl[0];
    assign ctl_wrap = ctl[1];
    assign ctl_en   = ctl[2];

    assign push_req  = wr_en && (reg_idx == IDX_WORD) && (byte_idx == 2'd3);
    assign fifo_push = push_req && !fifo_full;
    assign ovf_clr   = wr_en && (reg_idx == IDX_STAT) && wr_data[2];

    // host register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) stage[i] <= '0;
            ctl   <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_en && reg_idx == IDX_WORD && byte_idx != 2'd3)
                stage[byte_idx] <= wr_data;
            if (wr_en && reg_idx == IDX_CTRL)
                ctl <= wr_data[2:0];
            if (push_req && fifo_full) ovf_q <= 1'b1;
            else if (ovf_clr)          ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_idx)
            IDX_WORD: rd_data = (byte_idx == 2'd3) ? 8'h00 : stage[byte_idx];
            IDX_CTRL: rd_data = {5'b0, ctl};
            IDX_STAT: rd_data = {4'b0, busy, ovf_q, fifo_full, fifo_empty};
            default:  rd_data = 8'h00;
        endcase
    end

    avtx_fifo #(.WIDTH(31), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   ({wr_data[6:0], stage[2], stage[1], stage[0]}),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    avtx_serializer #(.CLK_HZ(CLK_HZ)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctl_en),
        .fast       (ctl_fast),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (fifo_pop),
        .drv_hi     (drv_hi),
        .drv_lo     (drv_lo),
        .busy       (busy),
        .quiet      (tx_quiet)
    );

    assign line_hi = drv_hi && !ctl_wrap;
    assign line_lo = drv_lo && !ctl_wrap;
    assign wrap_hi = drv_hi && ctl_wrap;
    assign wrap_lo = drv_lo && ctl_wrap;

endmodule

// File: rtl/avtx_chk.sv
module avtx_chk (
    input logic clk,
    input logic rst_n,
    input logic line_hi,
    input logic line_lo,
    input logic wrap_hi,
    input logic wrap_lo,
    input logic drv_hi,
    input logic wrap_en,
    input logic tx_quiet,
    input logic drv_lo,
    input logic fifo_empty,
    input logic fifo_full,
    input logic fifo_pop,
    input logic ovf_q,
    input logic ovf_clr
);
    // R5: a pair never drives both levels
    p_pair_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo) && !(wrap_hi && wrap_lo));

    // R10: wrap mode mutes the external pair and mirrors the driver
    p_wrap_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_en |-> (!line_hi && !line_lo && wrap_hi == drv_hi));

    // R7: idle and gap states keep the line null
    p_quiet_null_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_quiet |-> (!drv_hi && !drv_lo));

    // R8: empty and full are never reported together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R9: the overflow flag is sticky until cleared
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_q) && !$past(ovf_clr)) |-> ovf_q);

    // R11: the serializer only takes a word the FIFO holds
    p_pop_filled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

endmodule

bind avword_tx avtx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_hi    (line_hi),
    .line_lo    (line_lo),
    .wrap_hi    (wrap_hi),
    .wrap_lo    (wrap_lo),
    .drv_hi     (drv_hi),
    .wrap_en    (ctl_wrap),
    .tx_quiet   (tx_quiet),
    .drv_lo     (drv_lo),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_pop   (fifo_pop),
    .ovf_q      (ovf_q),
    .ovf_clr    (ovf_clr)
);

// File: tb/tb_avword_tx.sv
`timescale 1ns/1ps
module tb_avword_tx;
    localparam int CLK_HZ = 800_000;
    localparam int DEPTH  = 4;
    localparam int HF     = CLK_HZ / 200_000;
    localparam int HS     = CLK_HZ / 25_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = '0;
    logic [1:0] byte_idx = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       line_hi, line_lo, wrap_hi, wrap_lo;

    int n_tests = 0;
    int n_fail  = 0;
    logic mon_wrap = 1'b0;
    int line_leak = 0;
    int wrap_leak = 0;

    always #10 clk = ~clk;

    avword_tx #(.CLK_HZ(CLK_HZ), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .byte_idx(byte_idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .line_hi(line_hi), .line_lo(line_lo), .wrap_hi(wrap_hi), .wrap_lo(wrap_lo)
    );

    logic s_hi, s_lo, s_act;
    assign s_hi  = mon_wrap ? wrap_hi : line_hi;
    assign s_lo  = mon_wrap ? wrap_lo : line_lo;
    assign s_act = s_hi || s_lo;

    always @(negedge clk) begin
        if (rst_n && mon_wrap && (line_hi || line_lo)) line_leak++;
        if (rst_n && !mon_wrap && (wrap_hi || wrap_lo)) wrap_leak++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [1:0] b, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; byte_idx = b; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [1:0] b, output logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; byte_idx = b;
        #1 d = rd_data;
    endtask

    task automatic push_word(input logic [31:0] v);
        wr(2'd0, 2'd0, v[7:0]);
        wr(2'd0, 2'd1, v[15:8]);
        wr(2'd0, 2'd2, v[23:16]);
        wr(2'd0, 2'd3, v[31:24]);
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] host);
        return {~^host[30:0], host[30:0]};
    endfunction

    // decode one word at the pins; sampled on negative edges
    task automatic capture(input int half, output logic [31:0] w,
                           output int cell_err, output int lvl_err, output bit to);
        logic [31:0] seq;
        int t;
        cell_err = 0; lvl_err = 0; to = 0; w = '0; seq = '0; t = 0;
        while (!s_act) begin
            @(negedge clk);
            t++;
            if (t > 8000) begin to = 1; return; end
        end
        for (int i = 0; i < 32; i++) begin
            int mark;
            mark = 0;
            seq[i] = s_hi;
            while (s_act) begin
                if (s_hi && s_lo) lvl_err++;
                if (s_hi != seq[i]) lvl_err++;
                mark++;
                @(negedge clk);
            end
            if (mark != half) cell_err++;
            if (i < 31) begin
                int nul;
                nul = 0;
                while (!s_act && nul < 4 * half) begin
                    nul++;
                    @(negedge clk);
                end
                if (nul != half) cell_err++;
            end
        end
        for (int i = 0; i < 32; i++) begin
            if (i < 8) w[7-i] = seq[i];
            else       w[i]   = seq[i];
        end
    endtask

    task automatic count_null(input int limit, output int n);
        n = 0;
        while (!s_act && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 4000; k++) begin
            rd(2'd2, 2'd0, s);
            if (!s[3]) return;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(!line_hi && !line_lo && !wrap_hi && !wrap_lo, "R1", "null outputs",
              {28'b0, line_hi, line_lo, wrap_hi, wrap_lo}, 32'h0);
        rd(2'd1, 2'd0, d);
        check(d == 8'h00, "R1", "control reset", {24'b0, d}, 32'h00);
        rd(2'd2, 2'd0, d);
        check(d == 8'h01, "R1", "status reset (R8 empty)", {24'b0, d}, 32'h01);
    endtask

    task automatic t_single_fast();
        logic [7:0] d;
        logic [31:0] w;
        int ce, le, n;
        bit to;
        wr(2'd0, 2'd0, 8'h3C);
        wr(2'd0, 2'd1, 8'hA5);
        wr(2'd0, 2'd2, 8'h96);
        rd(2'd0, 2'd0, d); check(d == 8'h3C, "R2", "byte 0 readback", {24'b0, d}, 32'h3C);
        rd(2'd0, 2'd1, d); check(d == 8'hA5, "R2", "byte 1 readback", {24'b0, d}, 32'hA5);
        rd(2'd0, 2'd2, d); check(d == 8'h96, "R2", "byte 2 readback", {24'b0, d}, 32'h96);
        rd(2'd0, 2'd3, d); check(d == 8'h00, "R2", "byte 3 reads zero", {24'b0, d}, 32'h00);
        wr(2'd0, 2'd3, 8'h41);
        count_null(200, n);
        check(n == 200, "R11", "disabled channel stays null", n, 200);
        rd(2'd2, 2'd0, d);
        check(d == 8'h00, "R8", "one word queued, idle", {24'b0, d}, 32'h00);
        wr(2'd1, 2'd0, 8'h05);
        rd(2'd2, 2'd0, d);
        check(d[3] == 1'b1, "R8", "busy while sending", {24'b0, d}, 32'h08);
        capture(HF, w, ce, le, to);
        check(!to, "R11", "word started after enable", {31'b0, to}, 32'h0);
        check(w == expect_word(32'h4196A53C), "R4", "decoded order and value (R2)",
              w, expect_word(32'h4196A53C));
        check(^w == 1'b1, "R3", "odd parity", {31'b0, ^w}, 32'h1);
        check(ce == 0, "R6", "fast cell timing errors", ce, 0);
        check(le == 0, "R5", "level errors", le, 0);
        wait_idle();
        rd(2'd2, 2'd0, d);
        check(d == 8'h01, "R8", "status after word", {24'b0, d}, 32'h01);
    endtask

    task automatic t_parity_override();
        logic [31:0] w;
        int ce, le;
        bit to;
        push_word(32'hFFFF_FFFF);
        capture(HF, w, ce, le, to);
        check(w == 32'h7FFF_FFFF, "R3", "host bit 32 ignored", w, 32'h7FFF_FFFF);
        wait_idle();
    endtask

    task automatic t_slow();
        logic [31:0] w;
        int ce, le;
        bit to;
        wr(2'd1, 2'd0, 8'h04);
        push_word(32'h0000_0001);
        capture(HS, w, ce, le, to);
        check(w == expect_word(32'h1), "R4", "slow word value", w, expect_word(32'h1));
        check(ce == 0 && !to, "R6", "slow cell timing errors", ce, 0);
        wait_idle();
    endtask

    task automatic t_gap();
        logic [31:0] w;
        int ce, le, n;
        bit to;
        wr(2'd1, 2'd0, 8'h01);
        push_word(32'h1234_5678);
        push_word(32'h0BAD_F00D);
        wr(2'd1, 2'd0, 8'h05);
        capture(HF, w, ce, le, to);
        check(w == expect_word(32'h1234_5678), "R11", "first in order", w, expect_word(32'h1234_5678));
        count_null(40 * HF, n);
        check(n >= 9 * HF && n < 40 * HF, "R7", "inter-word null cycles", n, 9 * HF);
        capture(HF, w, ce, le, to);
        check(w == expect_word(32'h0BAD_F00D), "R11", "second in order", w, expect_word(32'h0BAD_F00D));
        wait_idle();
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        logic [31:0] w;
        int ce, le, n;
        bit to;
        wr(2'd1, 2'd0, 8'h01);
        for (int k = 0; k < DEPTH; k++) push_word(32'hC000_0000 + k);
        rd(2'd2, 2'd0, d);
        check(d == 8'h02, "R8", "full flag", {24'b0, d}, 32'h02);
        push_word(32'h5555_5555);
        rd(2'd2, 2'd0, d);
        check(d == 8'h06, "R9", "overflow set", {24'b0, d}, 32'h06);
        wr(2'd2, 2'd0, 8'h00);
        rd(2'd2, 2'd0, d);
        check(d[2] == 1'b1, "R9", "overflow sticky", {24'b0, d}, 32'h06);
        wr(2'd2, 2'd0, 8'h04);
        rd(2'd2, 2'd0, d);
        check(d == 8'h02, "R9", "overflow cleared", {24'b0, d}, 32'h02);
        wr(2'd1, 2'd0, 8'h05);
        for (int k = 0; k < DEPTH; k++) begin
            capture(HF, w, ce, le, to);
            check(w == expect_word(32'hC000_0000 + k), "R9", "queued words intact",
                  w, expect_word(32'hC000_0000 + k));
        end
        count_null(30 * HF, n);
        check(n == 30 * HF, "R9", "dropped word never sent", n, 30 * HF);
        wait_idle();
    endtask

    task automatic t_wrap();
        logic [31:0] w;
        int ce, le;
        bit to;
        check(wrap_leak == 0, "R10", "wrap pair quiet in normal mode", wrap_leak, 0);
        wr(2'd1, 2'd0, 8'h07);
        mon_wrap = 1'b1;
        push_word(32'h00C3_E1AB);
        capture(HF, w, ce, le, to);
        check(w == expect_word(32'h00C3_E1AB) && !to, "R10", "wrap pair carries word",
              w, expect_word(32'h00C3_E1AB));
        wait_idle();
        check(line_leak == 0, "R10", "external pair quiet in wrap", line_leak, 0);
        wr(2'd1, 2'd0, 8'h05);
        mon_wrap = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_fast();
        t_parity_override();
        t_slow();
        t_gap();
        t_overflow();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule